// File: doc/BRIEF.md
# Unconditional Jump Execute Stage

This block executes the two unconditional control-transfer instructions of a 32-bit base integer core. Each cycle it may take an instruction word, the address of that instruction and the value read from the first source register. It then returns, one clock later, a request to steer fetch to a new address, and a request to write the return address into the register file.

A direct jump adds a 21-bit signed offset, spread across the instruction word, to its own address. An indirect jump adds a 12-bit signed offset to the register value and then clears the lowest bit of the sum. Both kinds write the address of the next instruction, never the destination, as the link. No link write is issued when the destination is register zero. A target whose bit 1 is set is not taken. The unit raises a misalignment flag, withholds both the redirect and the write, and reports the offending address.

Top module: `jmp_unit`

## Requirements
- R1: Opcode 1101111 is a direct jump: target = pc + sign-extended offset, where the offset bits [20], [10:1], [11], [19:12] sit in instruction bits 31, 30:21, 20, 19:12 and offset bit 0 is zero.
- R2: Opcode 1100111 with funct3 (bits 14:12) = 000 is an indirect jump: target = (rs1 value + sign-extended instruction bits 31:20) with bit 0 forced to 0.
- R3: A jump whose target is aligned writes pc + 4 as link data to the register index in instruction bits 11:7.
- R4: With destination index 0 the redirect still happens but no writeback is issued.
- R5: An indirect jump with destination 0 and offset 0 redirects to exactly the rs1 value and issues no writeback.
- R6: Any other opcode, or the indirect opcode with non-zero funct3, raises neither redirect, writeback nor misalignment.
- R7: If bit 1 of the final target is set, the misalignment flag rises, redirect and writeback stay low, and the target output carries the faulting address.
- R8: Outputs are registered: a result appears on the clock edge after the accepting edge, and only when the valid strobe was high at that edge.
- R9: A synchronous active-high reset clears redirect, writeback and misalignment flags.
- R10: All target and link sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the instruction inputs |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs1_val | input | 32 | First source register value |
| redirect_o | output | 1 | Steer fetch to target_o |
| target_o | output | 32 | Jump target, or faulting address |
| wb_en_o | output | 1 | Register write request |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Link value (pc + 4) |
| misalign_o | output | 1 | Target misaligned fault |

## Verification
The redirect and the link writeback are produced in the same cycle from a single accepted jump, so every table vector with a non-zero destination checks both outputs at that one sample: the target against the offset sum and the link against pc + 4. The misalignment fault competes with both in that cycle. Vectors with bit 1 set in the target, one for each jump kind, must show the fault raised while the redirect and the write are both held low. Destination-zero vectors split the pair the other way, with the redirect present and the write absent.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
    localparam int XLEN   = 32;
    localparam int REG_W  = 5;
    localparam int IMM_I_W = 12;
    localparam int IMM_J_W = 21;
    localparam int INSN_STEP = 4;

    localparam logic [6:0] OP_JDIR = 7'b1101111;
    localparam logic [6:0] OP_JIND = 7'b1100111;
    localparam logic [2:0] F3_JIND = 3'b000;

    typedef struct packed {
        logic             redirect;
        logic             wb_en;
        logic             misalign;
        logic [REG_W-1:0] rd;
        logic [XLEN-1:0]  target;
        logic [XLEN-1:0]  link;
    } jmp_out_t;
endpackage

// File: rtl/jmp_decode.sv
module jmp_decode
    import jmp_pkg::*;
(
    input  logic [31:0]      instr,
    output logic             is_dir,
    output logic             is_ind,
    output logic [REG_W-1:0] rd,
    output logic [XLEN-1:0]  imm_j,
    output logic [XLEN-1:0]  imm_i
);
    logic [IMM_J_W-1:0] raw_j;
    logic [IMM_I_W-1:0] raw_i;

    always_comb begin
        is_dir = (instr[6:0] == OP_JDIR);
        is_ind = (instr[6:0] == OP_JIND) && (instr[14:12] == F3_JIND);
        rd     = instr[11:7];
        raw_j  = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
        raw_i  = instr[31:20];
        imm_j  = {{(XLEN-IMM_J_W){raw_j[IMM_J_W-1]}}, raw_j};
        imm_i  = {{(XLEN-IMM_I_W){raw_i[IMM_I_W-1]}}, raw_i};
    end
endmodule

// File: rtl/jmp_target.sv
module jmp_target
    import jmp_pkg::*;
(
    input  logic            sel_ind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] imm_j,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] link,
    output logic            misalign
);
    logic [XLEN-1:0] base, offs, sum;

    always_comb begin
        base   = sel_ind ? rs1_val : pc;
        offs   = sel_ind ? imm_i : imm_j;
        sum    = base + offs;
        target = sel_ind ? {sum[XLEN-1:1], 1'b0} : sum;
        link   = pc + XLEN'(INSN_STEP);
        misalign = target[1];
    end
endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
    import jmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs1_val,
    output logic             redirect_o,
    output logic [XLEN-1:0]  target_o,
    output logic             wb_en_o,
    output logic [REG_W-1:0] wb_idx_o,
    output logic [XLEN-1:0]  wb_data_o,
    output logic             misalign_o
);
    logic             dec_dir, dec_ind;
    logic [REG_W-1:0] dec_rd;
    logic [XLEN-1:0]  dec_imm_j, dec_imm_i;
    logic [XLEN-1:0]  calc_tgt, calc_link;
    logic             calc_mis;
    jmp_out_t         out_d, out_q;

    jmp_decode u_dec (
        .instr (instr),
        .is_dir(dec_dir),
        .is_ind(dec_ind),
        .rd    (dec_rd),
        .imm_j (dec_imm_j),
        .imm_i (dec_imm_i)
    );

    jmp_target u_tgt (
        .sel_ind (dec_ind),
        .pc      (pc),
        .rs1_val (rs1_val),
        .imm_j   (dec_imm_j),
        .imm_i   (dec_imm_i),
        .target  (calc_tgt),
        .link    (calc_link),
        .misalign(calc_mis)
    );

    always_comb begin
        logic take;
        take            = in_valid && (dec_dir || dec_ind);
        out_d           = out_q;
        out_d.target    = calc_tgt;
        out_d.link      = calc_link;
        out_d.rd        = dec_rd;
        out_d.misalign  = take && calc_mis;
        out_d.redirect  = take && !calc_mis;
        out_d.wb_en     = take && !calc_mis && (dec_rd != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.redirect <= 1'b0;
            out_q.wb_en    <= 1'b0;
            out_q.misalign <= 1'b0;
            out_q.rd       <= '0;
            out_q.target   <= '0;
            out_q.link     <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign redirect_o = out_q.redirect;
    assign target_o   = out_q.target;
    assign wb_en_o    = out_q.wb_en;
    assign wb_idx_o   = out_q.rd;
    assign wb_data_o  = out_q.link;
    assign misalign_o = out_q.misalign;

    // R7
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (!redirect_o && !wb_en_o));
    // R7
    fault_bit_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> target_o[1]);
    // R4
    no_x0_write_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> (wb_idx_o != '0) && redirect_o);
    // R3
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> (wb_data_o == $past(pc) + XLEN'(INSN_STEP)));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!redirect_o && !wb_en_o && !misalign_o));
    // R2
    ind_even_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid && dec_ind) && redirect_o) |-> !target_o[0]);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!redirect_o && !wb_en_o && !misalign_o));
endmodule

// File: tb/jmp_unit_tb.sv
module jmp_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc;
        logic [31:0] rs1;
        logic        redir;
        logic        wb;
        logic        mis;
        logic [4:0]  rd;
        logic [31:0] tgt;
        logic [31:0] link;
        logic [3:0]  req;
    } vec_t;

    function automatic logic [31:0] enc_dir(input logic [4:0] rd, input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_ind(input logic [4:0] rd, input logic [11:0] off,
                                            input logic [2:0] f3);
        return {off, 5'd1, f3, rd, 7'b1100111};
    endfunction

    function automatic vec_t mk(input logic [31:0] i, input logic [31:0] p, input logic [31:0] r,
                                input logic rd_f, input logic wb_f, input logic ms_f,
                                input logic [4:0] rd, input logic [31:0] t, input logic [31:0] l,
                                input logic [3:0] q);
        return '{i, p, r, rd_f, wb_f, ms_f, rd, t, l, q};
    endfunction

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R1 forward direct jump
        mk(enc_dir(5'd1, 21'h000100), 32'h0000_1000, 32'h0, 1, 1, 0, 5'd1, 32'h0000_1100, 32'h0000_1004, 4'd1),
        // R1 backward direct jump
        mk(enc_dir(5'd5, 21'h1FF800), 32'h0000_2000, 32'h0, 1, 1, 0, 5'd5, 32'h0000_1800, 32'h0000_2004, 4'd1),
        // R1 large positive offset
        mk(enc_dir(5'd2, 21'h0FFFFC), 32'h0000_0000, 32'h0, 1, 1, 0, 5'd2, 32'h000F_FFFC, 32'h0000_0004, 4'd1),
        // R2 indirect, bit 0 cleared
        mk(enc_ind(5'd1, 12'h010, 3'b000), 32'h0000_0500, 32'h0000_3001, 1, 1, 0, 5'd1, 32'h0000_3010, 32'h0000_0504, 4'd2),
        // R2 indirect, negative offset
        mk(enc_ind(5'd3, 12'hFFC, 3'b000), 32'h0000_0040, 32'h0000_4000, 1, 1, 0, 5'd3, 32'h0000_3FFC, 32'h0000_0044, 4'd2),
        // R4 direct jump to x0
        mk(enc_dir(5'd0, 21'h000008), 32'h0000_0100, 32'h0, 1, 0, 0, 5'd0, 32'h0000_0108, 32'h0, 4'd4),
        // R5 return form
        mk(enc_ind(5'd0, 12'h000, 3'b000), 32'h0000_0200, 32'h0000_8888, 1, 0, 0, 5'd0, 32'h0000_8888, 32'h0, 4'd5),
        // R6 branch opcode
        mk(32'h0000_0063, 32'h0000_0300, 32'h0000_1234, 0, 0, 0, 5'd0, 32'h0, 32'h0, 4'd6),
        // R6 indirect opcode, funct3 = 001
        mk(enc_ind(5'd4, 12'h000, 3'b001), 32'h0000_0300, 32'h0000_1234, 0, 0, 0, 5'd0, 32'h0, 32'h0, 4'd6),
        // R7 indirect misaligned
        mk(enc_ind(5'd1, 12'h000, 3'b000), 32'h0000_0600, 32'h0000_1002, 0, 0, 1, 5'd0, 32'h0000_1002, 32'h0, 4'd7),
        // R7 direct misaligned
        mk(enc_dir(5'd1, 21'h000006), 32'h0000_0100, 32'h0, 0, 0, 1, 5'd0, 32'h0000_0106, 32'h0, 4'd7),
        // R10 direct wrap
        mk(enc_dir(5'd6, 21'h000020), 32'hFFFF_FFF0, 32'h0, 1, 1, 0, 5'd6, 32'h0000_0010, 32'hFFFF_FFF4, 4'd10),
        // R10 indirect wrap, link wrap
        mk(enc_ind(5'd7, 12'h001, 3'b000), 32'hFFFF_FFFC, 32'hFFFF_FFFF, 1, 1, 0, 5'd7, 32'h0000_0000, 32'h0000_0000, 4'd10)
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, pc = '0, rs1_val = '0;
    logic        redirect_o, wb_en_o, misalign_o;
    logic [31:0] target_o, wb_data_o;
    logic [4:0]  wb_idx_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jmp_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc), .rs1_val(rs1_val),
        .redirect_o(redirect_o), .target_o(target_o), .wb_en_o(wb_en_o),
        .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .misalign_o(misalign_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic r, input logic w, input logic m);
        chk(req, "redirect", {31'b0, redirect_o}, {31'b0, r});
        chk(req, "wb_en", {31'b0, wb_en_o}, {31'b0, w});
        chk(req, "misalign", {31'b0, misalign_o}, {31'b0, m});
    endtask

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk_flags("R9", 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        // R8 table walked back to back, one result per cycle
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            if (k > 0) begin
                tag = $sformatf("R%0d", VECS[k-1].req);
                chk_flags(tag, VECS[k-1].redir, VECS[k-1].wb, VECS[k-1].mis);
                if (VECS[k-1].redir || VECS[k-1].mis) chk(tag, "target", target_o, VECS[k-1].tgt);
                if (VECS[k-1].wb) begin
                    chk(tag, "link", wb_data_o, VECS[k-1].link);
                    chk(tag, "rd", {27'b0, wb_idx_o}, {27'b0, VECS[k-1].rd});
                end
            end
            in_valid = 1'b1;
            instr = VECS[k].instr; pc = VECS[k].pc; rs1_val = VECS[k].rs1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        tag = $sformatf("R%0d", VECS[NV-1].req);
        chk_flags(tag, VECS[NV-1].redir, VECS[NV-1].wb, VECS[NV-1].mis);
        chk(tag, "target", target_o, VECS[NV-1].tgt);
        chk(tag, "link", wb_data_o, VECS[NV-1].link);

        // R8 valid low: a jump on the inputs is ignored
        instr = enc_dir(5'd1, 21'h000040); pc = 32'h0000_0800;
        @(negedge clk);
        chk_flags("R8", 1'b0, 1'b0, 1'b0);

        // R8 latency: not visible before the edge after acceptance
        in_valid = 1'b1;
        #1;
        chk_flags("R8", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk_flags("R8", 1'b1, 1'b1, 1'b0);
        chk("R1", "target", target_o, 32'h0000_0840);
        chk("R3", "link", wb_data_o, 32'h0000_0804);

        // R9 reset overrides a valid jump
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk_flags("R9", 1'b0, 1'b0, 1'b0);
        in_valid = 1'b0; rst = 1'b0;

        // R5 return form with large link register value
        in_valid = 1'b1; instr = enc_ind(5'd0, 12'h000, 3'b000);
        pc = 32'h0000_0A00; rs1_val = 32'hFFFF_0004;
        @(negedge clk);
        in_valid = 1'b0;
        chk_flags("R5", 1'b1, 1'b0, 1'b0);
        chk("R5", "target", target_o, 32'hFFFF_0004);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule